// File: doc/BRIEF.md
# Bit-Slip Word Aligner

This block sits behind a deserializer in a serial receiver. Each cycle of the parallel clock it receives one 8-bit word, and it passes on a re-framed 8-bit word. The word boundary moves later in the serial stream by exactly one bit each time the slip control line goes from low to high. The bit that was least significant in the older word is treated as earlier in time than the most significant bit of the newer word. The logic that decides when to slip sits outside the block.

The block also keeps the previous output word. When the newest output word, as the upper byte, together with the word before it, as the lower byte, equals a programmable 16-bit alignment pattern, a pattern-hit flag is high for that cycle. A controller outside the block can watch this flag, or the output words, and pulse the slip line until the framing is right.

Top module: `bit_slip_aligner`

## Requirements
- R1: Each low-to-high transition of `slip_i` adds exactly one bit of delay to the framing. Holding `slip_i` high causes no further slip. A level that was already high while reset was asserted does not count as a transition when reset is released.
- R2: With slip offset k (0 to 7), the word registered at a clock edge is bits [k+7:k] of the 16-bit window {previous input word, current input word}. In the output this is the stream delayed by k bits, most significant bit first. For example, with 8'hF0 arriving on every cycle, offsets 1, 2, 3 and 4 give 8'h78, 8'h3C, 8'h1E and 8'h0F.
- R3: A transition of `slip_i` that is sampled at a clock edge leaves the word registered at that same edge unchanged. The new offset first applies to the word registered at the next edge.
- R4: After eight slips the offset returns to 0, which restores the original framing.
- R5: `pat_hit_o` is high in a cycle exactly when {`word_o`, previous `word_o`} equals `align_pat_i`, using the pattern value sampled at the edge that registered `word_o`. For example, 8'h1E followed by 8'h0F matches 16'h0F1E.
- R6: The match is tested on every cycle, whether or not a slip has just occurred. A single matching window gives a one-cycle pulse. Consecutive matching windows keep `pat_hit_o` high.
- R7: Synchronous reset (`rst` high at a clock edge) sets the offset to 0, clears the input history and `word_o` to zero, and clears `pat_hit_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_word_i | input | 8 | Raw parallel word from the deserializer |
| slip_i | input | 1 | Slip control level; each rising transition slips one bit |
| align_pat_i | input | 16 | Alignment pattern, newer word in bits [15:8] |
| word_o | output | 8 | Re-framed output word, registered |
| pat_hit_o | output | 1 | High while the two-word output window equals the pattern |

## Verification
The embedded properties check the following on every cycle:
- the offset only ever steps by one, with wrap;
- the offset never moves while the slip level was already high;
- every high `pat_hit_o` is backed by a matching two-word output window;
- reset clears the outputs.

Only the bench scenarios can show the rest: the exact bit picked at each offset for a known stream, the one-cycle delay between a slip transition and the changed word, the return to the original framing after eight slips, a slip level held through reset, and a hit flag that stays high across back-to-back matches.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  localparam int unsigned DEF_WORD_W = 8;

  // Width of an offset counter able to index every bit of a word.
  function automatic int unsigned off_bits(input int unsigned w);
    return (w > 1) ? $clog2(w) : 1;
  endfunction

endpackage

// File: rtl/bsa_slip_ctrl.sv
module bsa_slip_ctrl
  import bsa_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  localparam int unsigned OFF_W = off_bits(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slip_i,
  output logic [OFF_W-1:0] off_o
);

  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(WORD_W - 1);

  logic             lvl_q;
  logic [OFF_W-1:0] off_q;
  logic             rise;

  assign rise = slip_i & ~lvl_q;

  always_ff @(posedge clk) begin
    lvl_q <= slip_i;   // level captured in reset too: held level is no edge
    if (rst) begin
      off_q <= '0;
    end else if (rise) begin
      off_q <= (off_q == OFF_LAST) ? '0 : off_q + 1'b1;
    end
  end

  assign off_o = off_q;

  // R1 / R4: offset moves only by one step, wrapping after the last bit
  p_step_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(off_q) |-> (($past(off_q) == OFF_LAST) ? (off_q == '0)
                                                   : (off_q == $past(off_q) + 1'b1)));

  // R1: a level that was already high never slips again
  p_held_level_r1: assert property (@(posedge clk) disable iff (rst)
    lvl_q |=> $stable(off_q));

endmodule

// File: rtl/bsa_framer.sv
module bsa_framer
  import bsa_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  localparam int unsigned OFF_W = off_bits(WORD_W),
  localparam int unsigned WIN_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] din_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [WORD_W-1:0] word_next_o,
  output logic [WORD_W-1:0] word_q_o
);

  logic [WORD_W-1:0] hist_q;
  logic [WORD_W-1:0] word_q;
  logic [WIN_W-1:0]  window;
  logic [WORD_W-1:0] cand [WORD_W];

  // older word in the upper half: its low bits precede the newer word
  assign window = {hist_q, din_i};

  for (genvar k = 0; k < WORD_W; k++) begin : g_cand
    assign cand[k] = window[k +: WORD_W];
  end

  always_comb begin
    word_next_o = cand[0];
    for (int k = 1; k < WORD_W; k++) begin
      if (off_i == OFF_W'(k)) word_next_o = cand[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      word_q <= '0;
    end else begin
      hist_q <= din_i;
      word_q <= word_next_o;
    end
  end

  assign word_q_o = word_q;

  // R2: at offset zero the registered word is the raw input word
  p_zero_offset_r2: assert property (@(posedge clk) disable iff (rst)
    (off_i == '0) |=> (word_q == $past(din_i)));

endmodule

// File: rtl/bsa_pat_match.sv
module bsa_pat_match
  import bsa_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  localparam int unsigned WIN_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_next_i,
  input  logic [WORD_W-1:0] word_q_i,
  input  logic [WIN_W-1:0]  pat_i,
  output logic              hit_o
);

  logic hit_q;

  // newer word (about to be registered) forms the upper half
  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= ({word_next_i, word_q_i} == pat_i);
  end

  assign hit_o = hit_q;

endmodule

// File: rtl/bit_slip_aligner.sv
module bit_slip_aligner
  import bsa_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  localparam int unsigned OFF_W = off_bits(WORD_W),
  localparam int unsigned PAT_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              slip_i,
  input  logic [PAT_W-1:0]  align_pat_i,
  output logic [WORD_W-1:0] word_o,
  output logic              pat_hit_o
);

  logic [OFF_W-1:0]  off;
  logic [WORD_W-1:0] word_next;
  logic [WORD_W-1:0] word_q;

  bsa_slip_ctrl #(.WORD_W(WORD_W)) u_slip (
    .clk    (clk),
    .rst    (rst),
    .slip_i (slip_i),
    .off_o  (off)
  );

  bsa_framer #(.WORD_W(WORD_W)) u_frame (
    .clk         (clk),
    .rst         (rst),
    .din_i       (rx_word_i),
    .off_i       (off),
    .word_next_o (word_next),
    .word_q_o    (word_q)
  );

  bsa_pat_match #(.WORD_W(WORD_W)) u_match (
    .clk         (clk),
    .rst         (rst),
    .word_next_i (word_next),
    .word_q_i    (word_q),
    .pat_i       (align_pat_i),
    .hit_o       (pat_hit_o)
  );

  assign word_o = word_q;

  // R5: every hit is backed by the two-word output window
  p_hit_window_r5: assert property (@(posedge clk) disable iff (rst)
    pat_hit_o |-> ({word_o, $past(word_o)} == $past(align_pat_i)));

  // R7: reset leaves a cleared output word and no hit
  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (word_o == '0) && !pat_hit_o);

  // R3: the slip transition itself does not alter the word registered with it
  p_slip_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (off == '0) && slip_i |=> (word_o == $past(rx_word_i)));

endmodule

// File: tb/bit_slip_aligner_tb_top.sv
module bit_slip_aligner_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  rx_word_i;
  logic        slip_i;
  logic [15:0] align_pat_i;
  logic [7:0]  word_o;
  logic        pat_hit_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bit_slip_aligner dut_i (
    .clk         (clk),
    .rst         (rst),
    .rx_word_i   (rx_word_i),
    .slip_i      (slip_i),
    .align_pat_i (align_pat_i),
    .word_o      (word_o),
    .pat_hit_o   (pat_hit_o)
  );

  // row: {slip, input word, expected word, expected hit}; pattern 16'h0F1E
  localparam int NV = 22;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 8'hF0, 8'hF0, 1'b0},  // 0 offset 0
    {1'b1, 8'hF0, 8'hF0, 1'b0},  // 1 R3 rise: word unchanged this edge
    {1'b1, 8'hF0, 8'h78, 1'b0},  // 2 R2 offset 1
    {1'b0, 8'hF0, 8'h78, 1'b0},  // 3
    {1'b1, 8'hF0, 8'h78, 1'b0},  // 4 rise
    {1'b0, 8'hF0, 8'h3C, 1'b0},  // 5 offset 2
    {1'b1, 8'hF0, 8'h3C, 1'b0},  // 6 rise
    {1'b1, 8'hF0, 8'h1E, 1'b0},  // 7 R1 held high: offset stays 3
    {1'b0, 8'hF0, 8'h1E, 1'b0},  // 8
    {1'b1, 8'hF0, 8'h1E, 1'b0},  // 9 rise
    {1'b0, 8'hF0, 8'h0F, 1'b1},  // 10 R5 hit {0F,1E}
    {1'b0, 8'hF0, 8'h0F, 1'b0},  // 11 R6 single pulse
    {1'b1, 8'hF0, 8'h0F, 1'b0},  // 12
    {1'b0, 8'hF0, 8'h87, 1'b0},  // 13 offset 5
    {1'b1, 8'hF0, 8'h87, 1'b0},  // 14
    {1'b0, 8'hF0, 8'hC3, 1'b0},  // 15 offset 6
    {1'b1, 8'hF0, 8'hC3, 1'b0},  // 16
    {1'b0, 8'hF0, 8'hE1, 1'b0},  // 17 offset 7
    {1'b1, 8'hF0, 8'hE1, 1'b0},  // 18 eighth slip
    {1'b0, 8'hF0, 8'hF0, 1'b0},  // 19 R4 wrapped to offset 0
    {1'b1, 8'hA5, 8'hA5, 1'b0},  // 20 rise
    {1'b0, 8'h3C, 8'h9E, 1'b0}   // 21 R2 window spans two words
  };

  task automatic check_word(input string req, input logic [7:0] exp);
    checks++;
    if (word_o !== exp) begin
      fails++;
      $display("FAIL %s word_o actual=%h expected=%h", req, word_o, exp);
    end
  endtask

  task automatic check_hit(input string req, input logic exp);
    checks++;
    if (pat_hit_o !== exp) begin
      fails++;
      $display("FAIL %s pat_hit_o actual=%b expected=%b", req, pat_hit_o, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; slip_i = 1'b0; rx_word_i = 8'hF0; align_pat_i = 16'h0F1E;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_word("R7", 8'h00);
    check_hit("R7", 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      slip_i    = VEC[i][17];
      rx_word_i = VEC[i][16:9];
      step();
      check_word("R2", VEC[i][8:1]);
      check_hit("R5", VEC[i][0]);
    end

    // R7 mid-stream reset (offset was 1), slip level held high throughout
    rst = 1'b1; slip_i = 1'b1; rx_word_i = 8'hF0; align_pat_i = 16'hF0F0;
    step();
    check_word("R7", 8'h00);
    check_hit("R7", 1'b0);
    step();
    rst = 1'b0;
    step();
    check_word("R1", 8'hF0);   // held level is no slip, offset 0
    check_hit("R6", 1'b0);     // {F0,00} does not match
    step();
    check_word("R1", 8'hF0);
    check_hit("R6", 1'b1);
    slip_i = 1'b0;
    step();
    check_word("R7", 8'hF0);   // reset restored offset 0
    check_hit("R6", 1'b1);     // consecutive matches keep it high

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule